// File: doc/BRIEF.md
# Routed System Interrupt Controller

This block gathers thirty-two level-sensitive system interrupt lines into a pending register. A fixed table turns each line into a processor interrupt level, and the block steers the resulting set of levels to one processor chosen by software, out of up to sixteen. Several lines share a level, the table is not monotonic in bit number, and some lines carry no level at all.

Software reaches the block through a small word-indexed register port with a write strobe and a combinational read path. Through that port it reads the pending lines, reads the disable mask, clears disable bits, sets disable bits, and reads or writes the target processor. The top bit of the disable mask acts as a global switch that holds every routed level off. For each processor the block drives a 16-bit hard-level vector and a copy of the global switch. It also drives a per-processor flag that follows the lines of level 15. The downstream per-processor stage consumes all of these.

Top module: `sirq_router`

## Requirements
- R1: After reset the pending readback (index 0) is 0, the target readback (index 4) is 0, the disable readback (index 1) is 0, the internal disable mask holds 0x0fa2007f, and every output vector and flag is 0.
- R2: Reading index 0 returns one bit per line that is high now and has a nonzero level. Lines 23 to 26 and line 31 have level 0 and never read back as pending.
- R3: Reading index 1 returns the disable mask ANDed with ~0x0fa2007f. A write to index 2 clears disable bits and a write to index 3 sets them. Both writes are first ANDed with ~0x0fa2007f, so lines 0-6, 17, 21 and 23-27 stay disabled for good.
- R4: A write to index 4 stores only the low 4 bits of the data as the target processor. Reading index 4 returns that value with all upper bits 0.
- R5: The line-to-level table: level 2 for lines 0 and 7, level 3 for 1 and 8, level 4 for 18, level 5 for 2 and 9, level 6 for 16, level 7 for 3 and 10, level 8 for 20, level 9 for 4, 11 and 21, level 10 for 19, level 11 for 5, 12 and 22, level 12 for 14 and 15, level 13 for 6, 13 and 17, and level 15 for 27 to 30. Bits 0, 1 and 14 of a hard-level vector are never set.
- R6: Only the processor whose number equals the target register receives a nonzero vector. That vector is the OR of (1 << level) over every pending, non-disabled line. Every other processor receives 0.
- R7: While bit 31 of the disable mask is set, the masterOff output is 1 and every hard-level vector is 0.
- R8: Disabling a line does not clear its pending bit. The pending bit tracks the line level whatever the mask holds.
- R9: Every bit of lvl15Pend is 1 exactly while some line of level 15 is high. This holds regardless of the disable mask and the target.
- R10: Reads of indexes 5 to 7 return 0. Writes to indexes 0, 1 and 5 to 7 change no state.
- R11: The outputs take their new value at the first rising clock edge after a register write or a line change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 32 | System interrupt lines, level sensitive |
| regAddr | input | 3 | Register word index for both read and write |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for regAddr |
| cpuHardLvl | output | NUM_CPU*16 | Hard-level vector per processor; processor c uses bits [c*16 +: 16] |
| masterOff | output | 1 | Global disable flag for the per-processor stage |
| lvl15Pend | output | NUM_CPU | Per-processor copy of the level-15 line state |

## Verification
The properties take regAddr to be a known index while reset is released, because the readback checks depend on it. They also take the source lines to be synchronous to clk. The bench drives every input only on the falling edge, so both hold. It samples registered outputs on the next falling edge, and it samples the combinational read path one step after it sets the index. The properties that involve the target also assume the target never names a processor above NUM_CPU-1. With the default of sixteen processors every 4-bit target value is a real processor, so no stimulus can break this assumption.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int SRC_W = 32;
  localparam int LVL_W = 16;
  localparam int IDX_W = 3;
  localparam int MASTER_BIT = 31;
  localparam logic [SRC_W-1:0] FORCED_OFF = 32'h0fa2_007f;
  localparam logic [SRC_W-1:0] WR_VALID = ~FORCED_OFF;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_PEND = 2'd1,
    RD_DIS  = 2'd2,
    RD_TGT  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   setDis;
    logic   clrDis;
    logic   ldTgt;
    rdSel_e rdSel;
  } sirqStrobe_t;

  // Fixed line-to-level mapping; 0 means the line carries no level.
  function automatic logic [3:0] lineLevel(input int b);
    case (b)
      0, 7:          lineLevel = 4'd2;
      1, 8:          lineLevel = 4'd3;
      18:            lineLevel = 4'd4;
      2, 9:          lineLevel = 4'd5;
      16:            lineLevel = 4'd6;
      3, 10:         lineLevel = 4'd7;
      20:            lineLevel = 4'd8;
      4, 11, 21:     lineLevel = 4'd9;
      19:            lineLevel = 4'd10;
      5, 12, 22:     lineLevel = 4'd11;
      14, 15:        lineLevel = 4'd12;
      6, 13, 17:     lineLevel = 4'd13;
      27, 28, 29, 30: lineLevel = 4'd15;
      default:       lineLevel = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] regAddr,
  output sirqStrobe_t      strobe
);

  always_comb begin
    strobe.setDis = wrEn && (regAddr == 3'd3);
    strobe.clrDis = wrEn && (regAddr == 3'd2);
    strobe.ldTgt  = wrEn && (regAddr == 3'd4);
    case (regAddr)
      3'd0:    strobe.rdSel = RD_PEND;
      3'd1:    strobe.rdSel = RD_DIS;
      3'd4:    strobe.rdSel = RD_TGT;
      default: strobe.rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int NUM_CPU = 16,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sirqStrobe_t              strobe,
  input  logic [SRC_W-1:0]         wrData,
  input  logic [SRC_W-1:0]         srcIn,
  output logic [SRC_W-1:0]         rdData,
  output logic [NUM_CPU*LVL_W-1:0] cpuHardLvl,
  output logic                     masterOff,
  output logic [NUM_CPU-1:0]       lvl15Pend
);

  logic [SRC_W-1:0] liveMask;
  logic [SRC_W-1:0] topMask;
  logic [SRC_W-1:0] pendQ, disQ;
  logic [TGT_W-1:0] tgtQ;
  logic [SRC_W-1:0] nextPend, nextDis, routedPend;
  logic [TGT_W-1:0] nextTgt;
  logic [LVL_W-1:0] lvlVec;
  logic             gateOpen;
  logic             anyTop;

  for (genvar b = 0; b < SRC_W; b++) begin : g_mask
    assign liveMask[b] = (lineLevel(b) != 4'd0);
    assign topMask[b]  = (lineLevel(b) == 4'd15);
  end

  always_comb begin
    nextPend = srcIn & liveMask;
    nextDis  = disQ;
    if (strobe.setDis) nextDis = disQ | (wrData & WR_VALID);
    if (strobe.clrDis) nextDis = disQ & ~(wrData & WR_VALID);
    nextTgt  = strobe.ldTgt ? wrData[TGT_W-1:0] : tgtQ;
  end

  assign routedPend = nextPend & ~nextDis;
  assign gateOpen   = !nextDis[MASTER_BIT];
  assign anyTop     = |(nextPend & topMask);

  always_comb begin
    lvlVec = '0;
    for (int b = 0; b < SRC_W; b++) begin
      if (routedPend[b]) lvlVec[lineLevel(b)] = 1'b1;
    end
    lvlVec[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ     <= '0;
      disQ      <= FORCED_OFF;
      tgtQ      <= '0;
      masterOff <= 1'b0;
    end else begin
      pendQ     <= nextPend;
      disQ      <= nextDis;
      tgtQ      <= nextTgt;
      masterOff <= nextDis[MASTER_BIT];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [LVL_W-1:0] hardD;
    assign hardD = (gateOpen && (nextTgt == TGT_W'(c))) ? lvlVec : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cpuHardLvl[c*LVL_W +: LVL_W] <= '0;
        lvl15Pend[c]                 <= 1'b0;
      end else begin
        cpuHardLvl[c*LVL_W +: LVL_W] <= hardD;
        lvl15Pend[c]                 <= anyTop;
      end
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_PEND: rdData = pendQ;
      RD_DIS:  rdData = disQ & WR_VALID;
      RD_TGT:  rdData = SRC_W'(tgtQ);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/sirq_router.sv
module sirq_router
  import sirq_pkg::*;
#(
  parameter int NUM_CPU = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [31:0]              srcIn,
  input  logic [2:0]               regAddr,
  input  logic                     wrEn,
  input  logic [31:0]              wrData,
  output logic [31:0]              rdData,
  output logic [NUM_CPU*16-1:0]    cpuHardLvl,
  output logic                     masterOff,
  output logic [NUM_CPU-1:0]       lvl15Pend
);

  sirqStrobe_t strobe;

  sirq_ctrl ctrl_i (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  sirq_datapath #(.NUM_CPU(NUM_CPU)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .srcIn      (srcIn),
    .rdData     (rdData),
    .cpuHardLvl (cpuHardLvl),
    .masterOff  (masterOff),
    .lvl15Pend  (lvl15Pend)
  );

endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk #(
  parameter int NUM_CPU = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2:0]            regAddr,
  input logic [31:0]           rdData,
  input logic [NUM_CPU*16-1:0] cpuHardLvl,
  input logic                  masterOff
);

  logic [NUM_CPU-1:0] cpuBusy;
  logic [NUM_CPU-1:0] cpuBadBit;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assign cpuBusy[c]   = |cpuHardLvl[c*16 +: 16];
    assign cpuBadBit[c] = |(cpuHardLvl[c*16 +: 16] & 16'h4003);
  end

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cpuBusy));

  assert_master_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    masterOff |-> (cpuBusy == '0));

  assert_no_dead_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd0) |-> ((rdData & 32'h8780_0000) == 32'h0));

  assert_stuck_bits_hidden_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1) |-> ((rdData & 32'h0fa2_007f) == 32'h0));

  assert_target_narrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd4) |-> (rdData[31:4] == 28'h0));

  assert_unused_levels_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuBadBit == '0);

endmodule

bind sirq_router sirq_router_chk #(.NUM_CPU(NUM_CPU)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .rdData     (rdData),
  .cpuHardLvl (cpuHardLvl),
  .masterOff  (masterOff)
);

// File: tb/sirq_router_tb.sv
module sirq_router_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 16;
  localparam int NROW = 12;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic [3:0]  cpu;
    logic [15:0] vec;
    logic        mst;
    logic        l15;
  } row_t;

  // Each row: optional write plus line levels, then the expected routing.
  localparam row_t TBL [NROW] = '{
    '{1'b0, 3'd0, 32'h0,          32'h0000_0080, 4'd0,  16'h0004, 1'b0, 1'b0},
    '{1'b0, 3'd0, 32'h0,          32'h0000_4100, 4'd0,  16'h1008, 1'b0, 1'b0},
    '{1'b1, 3'd4, 32'h0000_0035,  32'h0000_4100, 4'd5,  16'h1008, 1'b0, 1'b0},
    '{1'b1, 3'd3, 32'h0000_0100,  32'h0000_4100, 4'd5,  16'h1000, 1'b0, 1'b0},
    '{1'b1, 3'd2, 32'h0000_0101,  32'h0000_4100, 4'd5,  16'h1008, 1'b0, 1'b0},
    '{1'b0, 3'd0, 32'h0,          32'h8880_0001, 4'd5,  16'h0000, 1'b0, 1'b1},
    '{1'b0, 3'd0, 32'h0,          32'h1009_0000, 4'd5,  16'h8440, 1'b0, 1'b1},
    '{1'b1, 3'd3, 32'h8000_0000,  32'h1009_0000, 4'd5,  16'h0000, 1'b1, 1'b1},
    '{1'b1, 3'd2, 32'h8000_0000,  32'h1009_0000, 4'd5,  16'h8440, 1'b0, 1'b1},
    '{1'b1, 3'd7, 32'hffff_ffff,  32'h1009_0000, 4'd5,  16'h8440, 1'b0, 1'b1},
    '{1'b0, 3'd0, 32'h0,          32'h0052_2000, 4'd5,  16'h2900, 1'b0, 1'b0},
    '{1'b1, 3'd4, 32'h0000_000f,  32'h0000_1e00, 4'd15, 16'h0aa0, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [31:0]       srcIn = '0;
  logic [2:0]        regAddr = '0;
  logic              wrEn = 1'b0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [NCPU*16-1:0] cpuHardLvl;
  logic              masterOff;
  logic [NCPU-1:0]   lvl15Pend;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_router #(.NUM_CPU(NCPU)) dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .cpuHardLvl(cpuHardLvl),
    .masterOff(masterOff), .lvl15Pend(lvl15Pend)
  );

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [255:0] oneCpu(input int cpu, input logic [15:0] v);
    logic [255:0] r = '0;
    r[cpu*16 +: 16] = v;
    return r;
  endfunction

  task automatic readIdx(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    regAddr = idx;
    #1 val = rdData;
  endtask

  task automatic writeIdx(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    regAddr = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readIdx(3'd0, v); check("R1 pending", v, 0);
    readIdx(3'd1, v); check("R1 disable", v, 0);
    readIdx(3'd4, v); check("R1 target", v, 0);
    check("R1 vectors", cpuHardLvl, 0);
    check("R1 flags", {masterOff, lvl15Pend}, 0);

    // Table walk: R5 R6 R7 R9 R10 R3
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      srcIn = TBL[i].src; regAddr = TBL[i].addr;
      wrData = TBL[i].data; wrEn = TBL[i].wr;
      @(negedge clk);
      wrEn = 1'b0;
      check($sformatf("R5/R6 row %0d vectors", i), cpuHardLvl, oneCpu(TBL[i].cpu, TBL[i].vec));
      check($sformatf("R7 row %0d masterOff", i), masterOff, TBL[i].mst);
      check($sformatf("R9 row %0d lvl15Pend", i), lvl15Pend, {NCPU{TBL[i].l15}});
    end

    // R2: dead line 24 never pending
    @(negedge clk); srcIn = 32'h0100_1e00;
    readIdx(3'd0, v); check("R2 pending readback", v, 32'h0000_1e00);

    // R3/R7/R8: disable all
    writeIdx(3'd3, 32'hffff_ffff);
    readIdx(3'd1, v); check("R3 disable readback", v, 32'hf05d_ff80);
    check("R7 masterOff set", masterOff, 1'b1);
    check("R7 vectors held off", cpuHardLvl, 0);
    readIdx(3'd0, v); check("R8 pending kept", v, 32'h0000_1e00);

    writeIdx(3'd2, 32'hffff_ffff);
    readIdx(3'd1, v); check("R3 enable readback", v, 0);
    check("R3 routed again", cpuHardLvl, oneCpu(15, 16'h0aa0));

    // R4: target width
    readIdx(3'd4, v); check("R4 target readback", v, 32'hf);
    writeIdx(3'd4, 32'h0000_0123);
    readIdx(3'd4, v); check("R4 low bits kept", v, 32'h3);
    check("R6 moved to cpu3", cpuHardLvl, oneCpu(3, 16'h0aa0));

    // R10: unimplemented indexes
    writeIdx(3'd6, 32'hffff_ffff);
    writeIdx(3'd0, 32'hffff_ffff);
    readIdx(3'd1, v); check("R10 disable untouched", v, 0);
    readIdx(3'd4, v); check("R10 target untouched", v, 32'h3);
    check("R10 vectors untouched", cpuHardLvl, oneCpu(3, 16'h0aa0));
    for (int a = 5; a < 8; a++) begin
      readIdx(3'(a), v); check($sformatf("R10 read index %0d", a), v, 0);
    end

    // R11: timing of line change and of write
    @(negedge clk); srcIn = 32'h0;
    @(negedge clk); srcIn = 32'h1000_0000;
    #1 check("R11 before edge", cpuHardLvl, 0);
    @(negedge clk); check("R11 after edge", cpuHardLvl, oneCpu(3, 16'h8000));
    regAddr = 3'd4; wrData = 32'h6; wrEn = 1'b1;
    #1 check("R11 write before edge", cpuHardLvl, oneCpu(3, 16'h8000));
    @(negedge clk); wrEn = 1'b0;
    check("R11 write after edge", cpuHardLvl, oneCpu(6, 16'h8000));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule